// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

The block computes, for each of several 32-bit lanes, an integer dot product of two packed sources plus a 32-bit accumulator. An opcode chooses the element width (16, 8 or 4 bits, giving 2, 4 or 8 elements per word) and whether elements are signed or unsigned. Before the elements are split out, each source word is rebuilt from two 16-bit halves. Select controls pick which half of the source fills each half of the rebuilt word. Negate controls can invert those halves in signed modes.

Each elementwise product is conditioned on its own before it is summed. Signed products may be saturated and are then cut back to the element width with sign extension. Unsigned products may be saturated, or are otherwise kept at full width. The sum of the conditioned products plus the accumulator wraps modulo 2^32.

The result register is updated one clock after a valid input, and only in lanes whose execute-mask bit is set. A two-state output machine drives the output valid flag. Its states are EMPTY and FULL. It moves to FULL on any cycle with in_valid high and to EMPTY on any cycle with in_valid low.

Top module: `dotp_unit`

## Requirements
- R1: After reset, out_valid is 0 and every lane result is 0. out_valid equals the in_valid of the previous clock, so the output has a one-cycle latency.
- R2: Rebuilt operand A takes its bits [15:0] from src0[31:16] if sel_lo[0] is 1, else from src0[15:0]. It takes its bits [31:16] from src0[31:16] if sel_hi[0] is 1, else from src0[15:0]. Operand B is built the same way from src1 using sel_lo[1] and sel_hi[1].
- R3: op[0]=1 means unsigned and op[0]=0 means signed. op[2:1] selects the element width: 00 is 16 bits, 01 is 8 bits, 10 is 4 bits. Element i of width W occupies bits [i*W+W-1 : i*W].
- R4: In signed modes, elements are sign-extended and multiplied. Each product is reduced to its low W bits and sign-extended to 32 bits before it is summed. For example, 127*127 in 8-bit mode contributes 1.
- R5: In signed modes with clamp set, each product is first saturated to the range -(2^(W-1)) to 2^(W-1)-1.
- R6: In unsigned modes, elements are zero-extended and multiplied. With clamp set, each product is saturated to 2^W-1. Without clamp, the full product is summed unmasked.
- R7: The result is the sum of the conditioned products plus src2, taken modulo 2^32, with no final saturation.
- R8: In signed modes, neg_lo[k] and neg_hi[k] negate (two's complement, 16 bits) the selected low and high halves of source k. In unsigned modes these controls have no effect.
- R9: Opcodes 6 and 7 (op[2:1]=11) contribute no products, so the lane result equals src2.
- R10: A lane whose exec_mask bit is clear keeps its previous result. A lane with the bit set is written on a valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Mode: [0]=unsigned, [2:1]=width code |
| sel_lo | input | 2 | Half select for the low half of A (bit 0) and B (bit 1) |
| sel_hi | input | 2 | Half select for the high half of A (bit 0) and B (bit 1) |
| neg_lo | input | 2 | Negate the low half of A/B (signed modes) |
| neg_hi | input | 2 | Negate the high half of A/B (signed modes) |
| clamp | input | 1 | Saturate each product |
| exec_mask | input | LANES | Per-lane write enable |
| src0 | input | 32*LANES | Packed source 0, lane l at [32l+31:32l] |
| src1 | input | 32*LANES | Packed source 1 |
| src2 | input | 32*LANES | Accumulator per lane |
| out_valid | output | 1 | Result register was loaded last cycle |
| result | output | 32*LANES | Registered lane results |

## Verification
The only internal state is the output machine and the per-lane result registers. A fault in either shows at the ports on the very next clock, either as out_valid out of step with the previous in_valid or as a lane value differing from the reference model. A bad mask decision appears immediately as a held lane that changed, or a written lane that did not. Datapath faults in half selection, sign handling, clamping or truncation appear one cycle after the offending input. They are exposed most sharply by extreme elements, where saturation and truncation give values far from the plain product.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
    localparam int WORD = 32;
    localparam int HALF = 16;

    // op[2:1] width code
    typedef enum logic [1:0] {
        WC_16  = 2'b00,
        WC_8   = 2'b01,
        WC_4   = 2'b10,
        WC_RSV = 2'b11
    } width_code_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/dotp_operand.sv
module dotp_operand
    import dotp_pkg::*;
(
    input  logic [WORD-1:0] src,
    input  logic            pick_lo,
    input  logic            pick_hi,
    input  logic            inv_lo,
    input  logic            inv_hi,
    input  logic            is_signed,
    output logic [WORD-1:0] packed_op
);
    logic [HALF-1:0] lo_raw, hi_raw, lo_fin, hi_fin;

    always_comb begin
        lo_raw = pick_lo ? src[WORD-1:HALF] : src[HALF-1:0];
        hi_raw = pick_hi ? src[WORD-1:HALF] : src[HALF-1:0];
        lo_fin = (is_signed && inv_lo) ? (~lo_raw + 16'd1) : lo_raw;
        hi_fin = (is_signed && inv_hi) ? (~hi_raw + 16'd1) : hi_raw;
        packed_op = {hi_fin, lo_fin};
    end
endmodule

// File: rtl/dotp_width.sv
module dotp_width
    import dotp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [WORD-1:0] opa,
    input  logic [WORD-1:0] opb,
    input  logic            is_signed,
    input  logic            clamp,
    output logic [WORD-1:0] psum
);
    localparam int N  = WORD / W;
    localparam int PW = 2 * W;
    localparam logic signed [PW-1:0] SMAX = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [PW-1:0] SMIN = {{(W+1){1'b1}}, {(W-1){1'b0}}};
    localparam logic [PW-1:0]        UMAX = {{W{1'b0}}, {W{1'b1}}};

    logic [WORD-1:0] term [N];

    for (genvar i = 0; i < N; i++) begin : g_el
        logic [W-1:0]         ea, eb;
        logic signed [PW-1:0] ps, sc;
        logic [PW-1:0]        pu, uc;

        assign ea = opa[i*W +: W];
        assign eb = opb[i*W +: W];
        assign ps = $signed(ea) * $signed(eb);
        assign pu = PW'(ea) * PW'(eb);

        always_comb begin
            sc = ps;
            if (clamp && (ps > SMAX)) sc = SMAX;
            else if (clamp && (ps < SMIN)) sc = SMIN;
            uc = pu;
            if (clamp && (pu > UMAX)) uc = UMAX;
        end

        assign term[i] = is_signed ? WORD'($signed(sc[W-1:0])) : WORD'(uc);
    end

    always_comb begin
        psum = '0;
        for (int k = 0; k < N; k++) psum = psum + term[k];
    end
endmodule

// File: rtl/dotp_lane.sv
module dotp_lane
    import dotp_pkg::*;
(
    input  logic [WORD-1:0] src0,
    input  logic [WORD-1:0] src1,
    input  logic [WORD-1:0] acc,
    input  logic [2:0]      op,
    input  logic [1:0]      sel_lo,
    input  logic [1:0]      sel_hi,
    input  logic [1:0]      neg_lo,
    input  logic [1:0]      neg_hi,
    input  logic            clamp,
    output logic [WORD-1:0] sum
);
    logic        is_signed;
    width_code_e wcode;
    logic [WORD-1:0] opa, opb, prod;
    logic [WORD-1:0] wsum [3];

    assign is_signed = ~op[0];
    assign wcode     = width_code_e'(op[2:1]);

    dotp_operand u_opa (
        .src(src0), .pick_lo(sel_lo[0]), .pick_hi(sel_hi[0]),
        .inv_lo(neg_lo[0]), .inv_hi(neg_hi[0]),
        .is_signed(is_signed), .packed_op(opa)
    );
    dotp_operand u_opb (
        .src(src1), .pick_lo(sel_lo[1]), .pick_hi(sel_hi[1]),
        .inv_lo(neg_lo[1]), .inv_hi(neg_hi[1]),
        .is_signed(is_signed), .packed_op(opb)
    );

    for (genvar g = 0; g < 3; g++) begin : g_w
        dotp_width #(.W(16 >> g)) u_w (
            .opa(opa), .opb(opb), .is_signed(is_signed),
            .clamp(clamp), .psum(wsum[g])
        );
    end

    always_comb begin
        unique case (wcode)
            WC_16:   prod = wsum[0];
            WC_8:    prod = wsum[1];
            WC_4:    prod = wsum[2];
            default: prod = '0;
        endcase
        sum = prod + acc;
    end
endmodule

// File: rtl/dotp_unit.sv
module dotp_unit
    import dotp_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2:0]            op,
    input  logic [1:0]            sel_lo,
    input  logic [1:0]            sel_hi,
    input  logic [1:0]            neg_lo,
    input  logic [1:0]            neg_hi,
    input  logic                  clamp,
    input  logic [LANES-1:0]      exec_mask,
    input  logic [WORD*LANES-1:0] src0,
    input  logic [WORD*LANES-1:0] src1,
    input  logic [WORD*LANES-1:0] src2,
    output logic                  out_valid,
    output logic [WORD*LANES-1:0] result
);
    out_state_e state;

    always_ff @(posedge clk) begin
        if (!rst_n)        state <= ST_EMPTY;
        else if (in_valid) state <= ST_FULL;
        else               state <= ST_EMPTY;
    end

    always_comb begin
        unique case (state)
            ST_FULL:  out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [WORD-1:0] lsum;
        logic [WORD-1:0] lres;

        dotp_lane u_lane (
            .src0(src0[l*WORD +: WORD]), .src1(src1[l*WORD +: WORD]),
            .acc(src2[l*WORD +: WORD]), .op(op),
            .sel_lo(sel_lo), .sel_hi(sel_hi),
            .neg_lo(neg_lo), .neg_hi(neg_hi),
            .clamp(clamp), .sum(lsum)
        );

        always_ff @(posedge clk) begin
            if (!rst_n)                         lres <= '0;
            else if (in_valid && exec_mask[l])  lres <= lsum;
        end

        assign result[l*WORD +: WORD] = lres;

        // R10
        lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(in_valid && exec_mask[l]) |=> $stable(result[l*WORD +: WORD]));
    end

    // R1
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9
    reserved_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exec_mask[0] && op[2:1] == 2'b11)
        |=> result[WORD-1:0] == $past(src2[WORD-1:0]));
    // R4
    signed_nib_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exec_mask[0] && op == 3'd4 && src2[WORD-1:0] == '0)
        |=> ($signed(result[WORD-1:0]) >= -64 && $signed(result[WORD-1:0]) <= 56));
    // R6
    unsigned_clamp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exec_mask[0] && op == 3'd5 && clamp && src2[WORD-1:0] == '0)
        |=> result[WORD-1:0] <= 32'd120);
endmodule

// File: tb/tb_dotp_unit.sv
module tb_dotp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 2;
    localparam int WD_LIMIT = 100000;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic [2:0] op;
    logic [1:0] sel_lo, sel_hi, neg_lo, neg_hi;
    logic clamp;
    logic [LANES-1:0] exec_mask;
    logic [32*LANES-1:0] src0, src1, src2;
    logic out_valid;
    logic [32*LANES-1:0] result;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;
    string tag;

    logic [31:0] exp_res [LANES];
    logic        exp_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    dotp_unit #(.LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .sel_lo(sel_lo), .sel_hi(sel_hi), .neg_lo(neg_lo), .neg_hi(neg_hi),
        .clamp(clamp), .exec_mask(exec_mask),
        .src0(src0), .src1(src1), .src2(src2),
        .out_valid(out_valid), .result(result)
    );

    function automatic longint half_of(logic [31:0] w, bit hi);
        return hi ? longint'(w[31:16]) : longint'(w[15:0]);
    endfunction

    function automatic logic [31:0] ref_dot(int opc, logic [31:0] s0, logic [31:0] s1,
            logic [31:0] acc, logic [1:0] slo, logic [1:0] shi,
            logic [1:0] nlo, logic [1:0] nhi, bit clp);
        int w;
        bit sgn;
        longint a, b, lo, hi, ea, eb, p, sum, full, msk;
        sgn = (opc % 2) == 0;
        case (opc / 2)
            0: w = 16;
            1: w = 8;
            2: w = 4;
            default: return acc;
        endcase
        lo = half_of(s0, slo[0]); hi = half_of(s0, shi[0]);
        if (sgn && nlo[0]) lo = (65536 - lo) % 65536;
        if (sgn && nhi[0]) hi = (65536 - hi) % 65536;
        a = hi * 65536 + lo;
        lo = half_of(s1, slo[1]); hi = half_of(s1, shi[1]);
        if (sgn && nlo[1]) lo = (65536 - lo) % 65536;
        if (sgn && nhi[1]) hi = (65536 - hi) % 65536;
        b = hi * 65536 + lo;
        full = longint'(1) << w;
        msk = full - 1;
        sum = 0;
        for (int i = 0; i < 32 / w; i++) begin
            ea = (a >> (i * w)) & msk;
            eb = (b >> (i * w)) & msk;
            if (sgn) begin
                if (ea >= full / 2) ea = ea - full;
                if (eb >= full / 2) eb = eb - full;
                p = ea * eb;
                if (clp && p > full / 2 - 1) p = full / 2 - 1;
                if (clp && p < -(full / 2)) p = -(full / 2);
                p = p & msk;
                if (p >= full / 2) p = p - full;
            end else begin
                p = ea * eb;
                if (clp && p > msk) p = msk;
            end
            sum = sum + p;
        end
        sum = sum + longint'(acc);
        return sum[31:0];
    endfunction

    task automatic check_outputs();
        n_cmp++;
        if (out_valid !== exp_valid) begin
            n_bad++;
            $display("FAIL R1 out_valid actual=%b expected=%b", out_valid, exp_valid);
        end
        for (int l = 0; l < LANES; l++) begin
            n_cmp++;
            if (result[l*32 +: 32] !== exp_res[l]) begin
                n_bad++;
                $display("FAIL %s lane%0d actual=%h expected=%h", tag, l,
                         result[l*32 +: 32], exp_res[l]);
            end
        end
    endtask

    // inputs are set after a negedge; model updates at posedge; compare at negedge
    task automatic cycle();
        @(posedge clk);
        exp_valid = in_valid;
        for (int l = 0; l < LANES; l++)
            if (in_valid && exec_mask[l])
                exp_res[l] = ref_dot(int'(op), src0[l*32 +: 32], src1[l*32 +: 32],
                                     src2[l*32 +: 32], sel_lo, sel_hi, neg_lo, neg_hi, clamp);
        @(negedge clk);
        check_outputs();
    endtask

    function automatic string mode_tag(int opc, bit clp);
        if (opc >= 6) return "R9";
        if (opc % 2 == 1) return "R6";
        if (clp) return "R5";
        return "R4";
    endfunction

    task automatic drive(int opc, logic [31:0] a0, logic [31:0] b0, logic [31:0] c0,
            logic [31:0] a1, logic [31:0] b1, logic [31:0] c1);
        in_valid = 1'b1;
        op = 3'(opc);
        src0 = {a1, a0}; src1 = {b1, b0}; src2 = {c1, c0};
    endtask

    initial begin : watchdog
        while (cycles < WD_LIMIT && !done) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=%0d cycles expected<%0d", cycles, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pats [3][3];
        // per width: max positive, max negative, mixed
        pats[0][0] = 32'h7FFF7FFF; pats[0][1] = 32'h80008000; pats[0][2] = 32'h80007FFF;
        pats[1][0] = 32'h7F7F7F7F; pats[1][1] = 32'h80808080; pats[1][2] = 32'h807F807F;
        pats[2][0] = 32'h77777777; pats[2][1] = 32'h88888888; pats[2][2] = 32'h87878787;

        rst_n = 1'b0; in_valid = 1'b0; op = '0; sel_lo = '0; sel_hi = '0;
        neg_lo = '0; neg_hi = '0; clamp = 1'b0; exec_mask = '1;
        src0 = '0; src1 = '0; src2 = '0;
        exp_valid = 1'b0;
        for (int l = 0; l < LANES; l++) exp_res[l] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        check_outputs();  // reset state

        // R3: simple elements in each width, R1 latency
        tag = "R3";
        drive(0, 32'h0003_0002, 32'h0005_0004, 32'd0, 32'h0001_0001, 32'h0002_0002, 32'd10);
        cycle();
        drive(3, 32'h04030201, 32'h01010101, 32'd0, 32'hFF000000, 32'h02000000, 32'd1);
        cycle();
        drive(5, 32'h87654321, 32'h11111111, 32'd0, 32'hF000000F, 32'h10000001, 32'd0);
        cycle();
        in_valid = 1'b0;
        cycle();

        // R2: half selection with distinct halves
        tag = "R2";
        for (int s = 0; s < 16; s++) begin
            sel_lo = 2'(s); sel_hi = 2'(s >> 2);
            drive(1, 32'h0007_0003, 32'h0005_000B, 32'd0, 32'h1234_00FF, 32'h0100_0002, 32'd7);
            cycle();
        end
        sel_lo = 2'b00; sel_hi = 2'b11;

        // R4: 127*127 truncates to 1 per element
        tag = "R4";
        sel_lo = 2'b00; sel_hi = 2'b00;
        drive(2, 32'h7F7F7F7F, 32'h7F7F7F7F, 32'd0, 32'h80808080, 32'h7F7F7F7F, 32'd5);
        cycle();
        tag = "R5";
        clamp = 1'b1;
        drive(2, 32'h7F7F7F7F, 32'h7F7F7F7F, 32'd0, 32'h80808080, 32'h80808080, 32'd5);
        cycle();
        tag = "R6";
        drive(1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, 32'h000A0003, 32'h00010002, 32'd0);
        cycle();
        clamp = 1'b0;
        drive(1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, 32'h000A0003, 32'h00010002, 32'd0);
        cycle();

        // R7: accumulator wrap
        tag = "R7";
        drive(1, 32'h00010001, 32'h00010001, 32'hFFFFFFFF, 32'h00020000, 32'h00030000, 32'hFFFFFFFE);
        cycle();

        // R8: negation signed vs unsigned
        tag = "R8";
        neg_lo = 2'b01; neg_hi = 2'b10;
        drive(0, 32'h0003_0005, 32'h0002_0004, 32'd0, 32'h8000_0001, 32'h0001_8000, 32'd3);
        cycle();
        drive(1, 32'h0003_0005, 32'h0002_0004, 32'd0, 32'h8000_0001, 32'h0001_8000, 32'd3);
        cycle();
        neg_lo = 2'b00; neg_hi = 2'b00;

        // R9: reserved opcodes
        tag = "R9";
        drive(6, 32'h12345678, 32'h9ABCDEF0, 32'hCAFE0001, 32'h1, 32'h1, 32'h0BADF00D);
        cycle();
        drive(7, 32'h12345678, 32'h9ABCDEF0, 32'h00000042, 32'h1, 32'h1, 32'h0);
        cycle();

        // R10: masked lanes hold
        tag = "R10";
        exec_mask = 2'b01;
        drive(3, 32'h01010101, 32'h01010101, 32'd9, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd9);
        cycle();
        exec_mask = 2'b10;
        drive(3, 32'h02020202, 32'h02020202, 32'd0, 32'h03030303, 32'h03030303, 32'd0);
        cycle();
        exec_mask = 2'b00;
        drive(0, 32'hFFFF0001, 32'hFFFF0001, 32'd1, 32'h7FFF7FFF, 32'h7FFF7FFF, 32'd1);
        cycle();
        exec_mask = 2'b11;

        // exhaustive sweep: modes x clamp x selects x extreme patterns
        for (int m = 0; m < 8; m++)
            for (int c = 0; c < 2; c++)
                for (int s = 0; s < 16; s++)
                    for (int pa = 0; pa < 3; pa++)
                        for (int pb = 0; pb < 3; pb++) begin
                            int wi;
                            wi = (m / 2 > 2) ? 2 : m / 2;
                            tag = mode_tag(m, c[0]);
                            clamp = c[0];
                            sel_lo = 2'(s); sel_hi = 2'(s >> 2);
                            neg_lo = 2'($urandom_range(0, 3));
                            neg_hi = 2'($urandom_range(0, 3));
                            drive(m, pats[wi][pa], pats[wi][pb], $urandom,
                                  pats[wi][pb], pats[wi][pa], 32'd0);
                            cycle();
                        end

        // random traffic with gaps and masks
        for (int k = 0; k < 3000; k++) begin
            int m;
            m = $urandom_range(0, 7);
            clamp = 1'($urandom);
            tag = mode_tag(m, clamp);
            sel_lo = 2'($urandom); sel_hi = 2'($urandom);
            neg_lo = 2'($urandom); neg_hi = 2'($urandom);
            exec_mask = LANES'($urandom);
            drive(m, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
            in_valid = ($urandom_range(0, 3) != 0);
            if (exec_mask != '1) tag = "R10";
            cycle();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule